// File: doc/BRIEF.md
# Paired Register Store Execution Unit

This unit executes a single 32-bit store-pair instruction word. When `start` is pulsed it decodes the word and reads two data registers and one base register. The register file answers those reads combinationally. A base index of 31 selects a separate stack pointer value instead of a general register. From the base and a scaled 7-bit signed immediate it forms a 64-bit effective address. It then issues two data writes, one after the other, on a request/ready memory port. Afterwards it may hand the updated address back to the base register through a write-back port.

Three addressing forms are handled. The post-index form stores at the unmodified base and then updates the base. The pre-index form offsets the base, stores there and updates the base. The signed-offset form offsets the base, stores there and leaves the base unchanged. Each form comes in 32-bit word and 64-bit doubleword sizes. Encodings that do not belong to this instruction are reported with an undefined flag and cause no side effects. A misaligned stack pointer base is reported with an alignment-fault flag.

The case where a data register is also the written-back base follows one policy fixed at build time through `OVERLAP_POLICY`. A value of 0 (the default) stores the register values read before the update. A value of 1 reports the word as undefined. A value of 2 completes the word as a no-operation.

Top module: `pair_store_unit`

## Requirements
- R1: A word is accepted only if bits 29:27 equal 101, bit 26 is 0, bit 22 is 0, bits 31:30 are 00 or 10, and bits 25:23 are 001, 011 or 010. Any other word raises `undef` together with `done` one cycle after `start`, with no memory request and no write-back.
- R2: The byte offset is bits 21:15 taken as a two's-complement number and multiplied by 4 when bits 31:30 are 00, or by 8 when they are 10.
- R3: Bits 25:23 equal to 001 (post-index) give a first write address equal to the base. The values 011 (pre-index) and 010 (signed offset) give base plus offset.
- R4: The first write carries the register named by bits 4:0 to the first address. The second carries the register named by bits 14:10 to the first address plus 4 (32-bit) or plus 8 (64-bit). `mem_dword` is 1 for 64-bit. In 32-bit mode `mem_wdata` holds the low 32 bits of the register with the upper 32 bits at zero.
- R5: A write request holds its address, data and size until `mem_ready` is seen. The second request is raised only after the first has been accepted.
- R6: In the `done` cycle, the post-index and pre-index forms assert `wb_en` with `wb_data` equal to base plus offset and `wb_idx` equal to bits 9:5. The signed-offset form never asserts `wb_en`.
- R7: With bits 9:5 equal to 31, the base is `sp_data` and `wb_sp` is 1. If the low 4 bits of `sp_data` are not all zero, `align_fault` is raised with `done` and nothing is written.
- R8: With the default policy, a writeback form whose data index equals a base index other than 31 stores the pre-update register values and still writes the base back.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` is accepted through the `done` cycle. A `start` that arrives while `busy` is high is ignored.
- R10: All address arithmetic is 64-bit and wraps modulo 2^64.
- R11: After reset the unit is idle, with `busy`, `mem_req`, `done`, `undef`, `align_fault` and `wb_en` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing `instr` when idle |
| instr | input | 32 | Instruction word, held stable while `start` is high |
| busy | output | 1 | Unit is executing a word |
| rd_idx1 | output | 5 | First data register index (bits 4:0) |
| rd_idx2 | output | 5 | Second data register index (bits 14:10) |
| base_idx | output | 5 | Base register index (bits 9:5) |
| rd_data1 | input | 64 | Value of register `rd_idx1` |
| rd_data2 | input | 64 | Value of register `rd_idx2` |
| base_data | input | 64 | Value of register `base_idx` |
| sp_data | input | 64 | Stack pointer value |
| mem_req | output | 1 | Write request valid |
| mem_addr | output | 64 | Write byte address |
| mem_wdata | output | 64 | Write data, low-aligned |
| mem_dword | output | 1 | 1: 8-byte write, 0: 4-byte write |
| mem_ready | input | 1 | Memory accepts the current request |
| wb_en | output | 1 | Base write-back strobe |
| wb_sp | output | 1 | Write-back targets the stack pointer |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 64 | Updated base address |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined encoding, valid with `done` |
| align_fault | output | 1 | Stack pointer misalignment, valid with `done` |

## Verification
The assertions assume that `mem_ready` is only seen while a request is pending. They also assume that the register read values and `instr` are stable in the cycle `start` is sampled. The bench drives `mem_ready` high only at a falling edge where it has observed `mem_req`. It changes register contents and the instruction word only while the unit is idle. It never gives the value 31 to a data register index.

// File: rtl/pair_store_unit.sv
module pair_store_unit #(
  parameter int OVERLAP_POLICY = 0,
  parameter int SP_ALIGN_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  output logic        busy,
  output logic [4:0]  rd_idx1,
  output logic [4:0]  rd_idx2,
  output logic [4:0]  base_idx,
  input  logic [63:0] rd_data1,
  input  logic [63:0] rd_data2,
  input  logic [63:0] base_data,
  input  logic [63:0] sp_data,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic [63:0] mem_wdata,
  output logic        mem_dword,
  input  logic        mem_ready,
  output logic        wb_en,
  output logic        wb_sp,
  output logic [4:0]  wb_idx,
  output logic [63:0] wb_data,
  output logic        done,
  output logic        undef,
  output logic        align_fault
);
  localparam logic [4:0] SP_IDX = 5'd31;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_END} st_e;
  st_e st;

  wire [1:0] opc  = instr[31:30];
  wire [2:0] form = instr[25:23];
  wire [6:0] imm  = instr[21:15];

  assign rd_idx1  = instr[4:0];
  assign rd_idx2  = instr[14:10];
  assign base_idx = instr[9:5];

  wire form_ok = (form == 3'b001) || (form == 3'b011) || (form == 3'b010);
  wire enc_ok  = (instr[29:27] == 3'b101) && !instr[26] && !instr[22] && !opc[0] && form_ok;
  wire upd     = form[0];
  wire post    = !form[1];
  wire is_sp   = (base_idx == SP_IDX);

  wire [63:0] offs = opc[1] ? {{54{imm[6]}}, imm, 3'b000} : {{55{imm[6]}}, imm, 2'b00};
  wire [63:0] base = is_sp ? sp_data : base_data;
  wire [63:0] sum  = base + offs;

  wire overlap = upd && !is_sp && (rd_idx1 == base_idx || rd_idx2 == base_idx);
  wire sp_bad  = is_sp && (|sp_data[SP_ALIGN_BITS-1:0]);
  wire bad     = !enc_ok || (overlap && OVERLAP_POLICY == 1);
  wire skip    = enc_ok && overlap && OVERLAP_POLICY == 2;
  wire fault   = !bad && !skip && sp_bad;
  wire go      = !bad && !skip && !sp_bad;

  logic [63:0] ea, nb, d1, d2;
  logic        dw, upd_q, go_q, bad_q, fault_q, sp_q;
  logic [4:0]  n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ea      <= '0;
      nb      <= '0;
      d1      <= '0;
      d2      <= '0;
      dw      <= 1'b0;
      upd_q   <= 1'b0;
      go_q    <= 1'b0;
      bad_q   <= 1'b0;
      fault_q <= 1'b0;
      sp_q    <= 1'b0;
      n_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          ea      <= post ? base : sum;
          nb      <= sum;
          d1      <= opc[1] ? rd_data1 : {32'b0, rd_data1[31:0]};
          d2      <= opc[1] ? rd_data2 : {32'b0, rd_data2[31:0]};
          dw      <= opc[1];
          upd_q   <= upd;
          go_q    <= go;
          bad_q   <= bad;
          fault_q <= fault;
          sp_q    <= is_sp;
          n_q     <= base_idx;
          st      <= go ? ST_FIRST : ST_END;
        end
        ST_FIRST:  if (mem_ready) st <= ST_SECOND;
        ST_SECOND: if (mem_ready) st <= ST_END;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign mem_req     = (st == ST_FIRST) || (st == ST_SECOND);
  assign mem_addr    = (st == ST_SECOND) ? ea + (dw ? 64'd8 : 64'd4) : ea;
  assign mem_wdata   = (st == ST_SECOND) ? d2 : d1;
  assign mem_dword   = dw;
  assign done        = (st == ST_END);
  assign undef       = done && bad_q;
  assign align_fault = done && fault_q;
  assign wb_en       = done && go_q && upd_q;
  assign wb_sp       = sp_q;
  assign wb_idx      = n_q;
  assign wb_data     = nb;
endmodule

// File: rtl/pair_store_checks.sv
module pair_store_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic        mem_dword,
  input logic        done,
  input logic        undef,
  input logic        align_fault,
  input logic        wb_en
);
  logic        have1;
  logic [63:0] a1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have1 <= 1'b0;
      a1    <= '0;
    end else if (mem_req && mem_ready) begin
      if (!have1) begin
        a1    <= mem_addr;
        have1 <= 1'b1;
      end else begin
        p_second_addr_r4: assert (mem_addr == a1 + (mem_dword ? 64'd8 : 64'd4));
        have1 <= 1'b0;
      end
    end else if (done) begin
      p_pair_complete_r5: assert (!have1);
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_dword));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);
  p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !wb_en && !mem_req);
  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> done && !wb_en && !undef);
  p_wb_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
endmodule

bind pair_store_unit pair_store_checks u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_dword(mem_dword), .done(done),
  .undef(undef), .align_fault(align_fault), .wb_en(wb_en)
);

// File: tb/sim_pair_store_unit.sv
module sim_pair_store_unit;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_ready = 1'b0;
  logic [31:0] instr = '0;
  logic busy, mem_req, mem_dword, wb_en, wb_sp, done, undef, align_fault;
  logic [4:0] rd_idx1, rd_idx2, base_idx, wb_idx;
  logic [63:0] rd_data1, rd_data2, base_data, mem_addr, mem_wdata, wb_data;
  logic [63:0] xr [32];
  logic [63:0] sp = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign rd_data1  = xr[rd_idx1];
  assign rd_data2  = xr[rd_idx2];
  assign base_data = xr[base_idx];

  pair_store_unit u0 (.*, .sp_data(sp));

  function automatic logic [31:0] enc(logic [1:0] o, logic [2:0] f, logic [6:0] im,
                                      logic [4:0] t2, logic [4:0] n, logic [4:0] t);
    return {o, 3'b101, 1'b0, f, 1'b0, im, t2, n, t};
  endfunction

  typedef struct packed {
    logic [31:0] ins; logic [63:0] base; logic [63:0] a1;
    logic [3:0] nb; logic wb; logic [63:0] wbv; logic ud;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{enc(2'd2, 3'b010, 7'h02, 5'd2, 5'd3, 5'd1), 64'h1000, 64'h1010, 4'd8, 1'b0, 64'h0, 1'b0},
    '{enc(2'd0, 3'b011, 7'h7F, 5'd7, 5'd5, 5'd6), 64'h2000, 64'h1FFC, 4'd4, 1'b1, 64'h1FFC, 1'b0},
    '{enc(2'd2, 3'b001, 7'h40, 5'd10, 5'd8, 5'd9), 64'h8000, 64'h8000, 4'd8, 1'b1, 64'h7E00, 1'b0},
    '{enc(2'd0, 3'b001, 7'h3F, 5'd13, 5'd11, 5'd12), 64'h100, 64'h100, 4'd4, 1'b1, 64'h1FC, 1'b0},
    '{enc(2'd2, 3'b011, 7'h7E, 5'd2, 5'd31, 5'd1), 64'h4000, 64'h3FF0, 4'd8, 1'b1, 64'h3FF0, 1'b0},
    '{enc(2'd2, 3'b010, 7'h01, 5'd2, 5'd4, 5'd1), 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 4'd8, 1'b0, 64'h0, 1'b0},
    '{enc(2'd3, 3'b010, 7'h00, 5'd2, 5'd4, 5'd1), 64'h1000, 64'h0, 4'd0, 1'b0, 64'h0, 1'b1},
    '{enc(2'd1, 3'b010, 7'h00, 5'd2, 5'd4, 5'd1), 64'h1000, 64'h0, 4'd0, 1'b0, 64'h0, 1'b1},
    '{enc(2'd0, 3'b010, 7'h00, 5'd2, 5'd4, 5'd1) | 32'h0040_0000, 64'h1000, 64'h0, 4'd0, 1'b0, 64'h0, 1'b1},
    '{enc(2'd0, 3'b000, 7'h00, 5'd2, 5'd4, 5'd1), 64'h1000, 64'h0, 4'd0, 1'b0, 64'h0, 1'b1},
    '{enc(2'd0, 3'b010, 7'h00, 5'd2, 5'd4, 5'd1) ^ 32'h0800_0000, 64'h1000, 64'h0, 4'd0, 1'b0, 64'h0, 1'b1},
    '{enc(2'd2, 3'b011, 7'h01, 5'd4, 5'd3, 5'd3), 64'h500, 64'h508, 4'd8, 1'b1, 64'h508, 1'b0},
    '{enc(2'd0, 3'b010, 7'h40, 5'd15, 5'd14, 5'd16), 64'h1000, 64'hF00, 4'd4, 1'b0, 64'h0, 1'b0}
  };

  int nwr;
  logic [63:0] wa [2], wd [2];
  logic ws [2];
  logic g_done, g_undef, g_fault, g_wb, g_wbsp;
  logic [4:0] g_idx;
  logic [63:0] g_wbv;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_regs();
    for (int i = 0; i < 32; i++) xr[i] = 64'hF00D_0000_0000_0000 + i * 64'h0000_0101_0001_0003;
    sp = 64'h0;
  endtask

  task automatic run(input logic [31:0] w, input int delay);
    int wt = 0;
    @(negedge clk); instr = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
    nwr = 0; g_done = 0; g_undef = 0; g_fault = 0; g_wb = 0; g_wbsp = 0; g_idx = 0; g_wbv = 0;
    for (int c = 0; c < 60; c++) begin
      if (done) begin
        g_done = 1; g_undef = undef; g_fault = align_fault; g_wb = wb_en;
        g_wbsp = wb_sp; g_idx = wb_idx; g_wbv = wb_data;
        mem_ready = 1'b0;
        break;
      end
      if (mem_req) begin
        if (wt >= delay) begin
          mem_ready = 1'b1;
          if (nwr < 2) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; ws[nwr] = mem_dword; end
          nwr++; wt = 0;
        end else begin
          mem_ready = 1'b0; wt++;
        end
      end else mem_ready = 1'b0;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", {62'b0, done, busy}, 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e2, a_hold;
    init_regs();
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !undef && !align_fault && !wb_en, "R11 reset idle",
        {58'b0, busy, mem_req, done, undef, align_fault, wb_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R11 idle after reset", {61'b0, busy, mem_req, done}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t x = VEC[v];
      init_regs();
      if (x.ins[9:5] == 5'd31) sp = x.base; else xr[x.ins[9:5]] = x.base;
      e1 = (x.nb == 4'd4) ? {32'b0, xr[x.ins[4:0]][31:0]} : xr[x.ins[4:0]];
      e2 = (x.nb == 4'd4) ? {32'b0, xr[x.ins[14:10]][31:0]} : xr[x.ins[14:10]];
      run(x.ins, v % 3);
      chk(g_done, "R9 done seen", {63'b0, g_done}, 64'h1);
      chk(g_undef == x.ud, "R1 undef flag", {63'b0, g_undef}, {63'b0, x.ud});
      chk(!g_fault, "R7 no fault when aligned", {63'b0, g_fault}, 64'h0);
      if (x.ud) begin
        chk(nwr == 0 && !g_wb, "R1 no side effects", nwr, 0);
      end else begin
        chk(nwr == 2, "R5 two writes", nwr, 2);
        chk(wa[0] == x.a1, "R3 R2 R10 first address", wa[0], x.a1);
        chk(wa[1] == x.a1 + x.nb, "R4 R10 second address", wa[1], x.a1 + x.nb);
        chk(wd[0] == e1, "R4 R8 first data", wd[0], e1);
        chk(wd[1] == e2, "R4 second data", wd[1], e2);
        chk(ws[0] == (x.nb == 4'd8) && ws[1] == (x.nb == 4'd8), "R4 size", {63'b0, ws[0]}, {63'b0, x.nb == 4'd8});
        chk(g_wb == x.wb, "R6 writeback enable", {63'b0, g_wb}, {63'b0, x.wb});
        if (x.wb) begin
          chk(g_wbv == x.wbv, "R6 R8 writeback value", g_wbv, x.wbv);
          chk(g_idx == x.ins[9:5], "R6 writeback index", {59'b0, g_idx}, {59'b0, x.ins[9:5]});
          chk(g_wbsp == (x.ins[9:5] == 5'd31), "R7 writeback to sp", {63'b0, g_wbsp}, {63'b0, x.ins[9:5] == 5'd31});
        end
      end
    end

    init_regs();
    sp = 64'h4008;
    run(enc(2'd2, 3'b011, 7'h7E, 5'd2, 5'd31, 5'd1), 0);
    chk(g_done && g_fault && !g_undef, "R7 misaligned sp fault", {62'b0, g_fault, g_undef}, 64'h2);
    chk(nwr == 0 && !g_wb, "R7 fault has no side effects", nwr, 0);

    init_regs();
    xr[3] = 64'h1000;
    @(negedge clk); instr = VEC[0].ins; start = 1'b1;
    @(negedge clk); start = 1'b0; mem_ready = 1'b0;
    a_hold = mem_addr;
    repeat (3) @(negedge clk);
    instr = enc(2'd0, 3'b011, 7'h05, 5'd7, 5'd5, 5'd6); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_req && mem_addr == a_hold, "R5 request held while not ready", mem_addr, a_hold);
    instr = VEC[0].ins;
    nwr = 0;
    for (int c = 0; c < 20 && !done; c++) begin
      mem_ready = mem_req;
      if (mem_req && nwr < 2) wa[nwr] = mem_addr;
      if (mem_req) nwr++;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    chk(done && !wb_en, "R9 done after stalled pair", {62'b0, done, wb_en}, 64'h2);
    chk(nwr == 2 && wa[1] == 64'h1018, "R9 start while busy ignored", wa[1], 64'h1018);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R9 no extra execution", {62'b0, busy, mem_req}, 64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule